// File: doc/BRIEF.md
# Two-Thread Partitioned Instruction Queue

This block buffers decoded instructions for a core that runs two hardware threads. Each thread has its own write port with valid, ready and an opaque payload word. A front-end arbiter takes at most one write per cycle, and the threads take turns. A single read port returns the buffered entries. Within a thread the entries come out in the order they were written, and each entry carries a bit that says which thread owns it.

In two-thread mode the storage is split into two fixed halves. A thread that stalls or runs slowly can fill only its own half, so it never blocks the other thread's writes. In one-thread mode thread 0 owns every entry and thread 1's port is closed. A mode change is requested on a level input. While the request is pending, both write ports stop taking entries. Entries already held are not discarded: they keep draining at the read port. The new mode takes effect on the first edge at which the queue is empty.

Top module: `smt_iq`

## Requirements
- R1: After reset the queue is empty, `deq_valid` is 0, the block is in one-thread mode (`dual_mode` = 0), `t1_ready` is 0, and `t0_ready` is 1 when `dual_req` is 0.
- R2: Entries of one thread leave the read port in the order in which that thread wrote them, with the same payload.
- R3: In two-thread mode each thread holds at most N/2 entries. A thread's ready drops in the cycle its half becomes full, and the other thread's writes are still accepted.
- R4: In one-thread mode thread 0 may hold all N entries, and `t1_ready` stays 0.
- R5: At most one write is accepted per cycle. When both threads can write, the grant goes to the thread that was not granted last. When only one thread can write, that thread gets the grant. After reset, thread 0 has the first turn.
- R6: `deq_valid` is 1 whenever any entry is held. When both threads hold entries, the read port serves the thread that was not served last. `deq_tid` gives the owning thread (0 or 1). After reset, thread 0 is preferred.
- R7: A thread whose part is full has its ready set again in the cycle after a read removes one of its entries.
- R8: While `dual_req` differs from `dual_mode`, both ready outputs are 0. `dual_mode` takes the value of `dual_req` on the first clock edge at which the queue holds no entry, and it never changes while entries are held.
- R9: Writes to and reads from one thread never change the entries held by the other thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_req | input | 1 | Requested mode: 1 for two threads, 0 for thread 0 only |
| t0_valid | input | 1 | Thread 0 offers an entry |
| t0_data | input | W | Thread 0 payload |
| t0_ready | output | 1 | Thread 0 entry is taken this cycle if valid |
| t1_valid | input | 1 | Thread 1 offers an entry |
| t1_data | input | W | Thread 1 payload |
| t1_ready | output | 1 | Thread 1 entry is taken this cycle if valid |
| deq_ready | input | 1 | Consumer takes the head entry |
| deq_valid | output | 1 | An entry is presented |
| deq_data | output | W | Payload of the presented entry |
| deq_tid | output | 1 | Owning thread of the presented entry |
| dual_mode | output | 1 | Current mode |

## Verification
The ready outputs and the read port depend combinationally on the registered state and on the current valids. The bench therefore samples them in the same cycle the inputs are driven, one time unit after the falling edge. An accepted write or a read changes occupancy at the next rising edge, so a full thread's ready returns at the first sample after that edge. A pending mode change takes effect at the edge after the queue is seen empty, and the bench expects `dual_mode` to change exactly there. A model of both queues, both turn bits and the mode advances at each rising edge and predicts every sampled output.

// File: rtl/smt_iq.sv
module smt_iq #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dual_req,
  input  logic         t0_valid,
  input  logic [W-1:0] t0_data,
  output logic         t0_ready,
  input  logic         t1_valid,
  input  logic [W-1:0] t1_data,
  output logic         t1_ready,
  input  logic         deq_ready,
  output logic         deq_valid,
  output logic [W-1:0] deq_data,
  output logic         deq_tid,
  output logic         dual_mode
);
  localparam int AW = $clog2(N);
  localparam int CW = AW + 1;
  localparam int HALF = N / 2;

  logic [W-1:0] mem [N];
  logic [1:0][AW-1:0] head, tail;
  logic [1:0][CW-1:0] cnt;
  logic eturn, dturn;

  function automatic logic [AW-1:0] phys(input logic d, input logic t, input logic [AW-1:0] p);
    return d ? {t, p[AW-2:0]} : p;
  endfunction

  function automatic logic [AW-1:0] nxt(input logic d, input logic [AW-1:0] p);
    return d ? {1'b0, p[AW-2:0] + 1'b1} : p + 1'b1;
  endfunction

  logic [CW-1:0] cap;
  logic pend, sp0, sp1, acc0, acc1, grant1, enq, etid;
  logic ne0, ne1, dsel, deq;

  assign cap  = dual_mode ? CW'(HALF) : CW'(N);
  assign pend = dual_req != dual_mode;
  assign sp0  = !pend && (cnt[0] < cap);
  assign sp1  = !pend && dual_mode && (cnt[1] < cap);
  assign acc0 = t0_valid && sp0;
  assign acc1 = t1_valid && sp1;

  assign t0_ready = sp0 && (!eturn || !acc1);
  assign t1_ready = sp1 && (eturn || !acc0);
  assign grant1   = t1_valid && t1_ready;
  assign enq      = (t0_valid && t0_ready) || grant1;
  assign etid     = grant1;

  assign ne0       = cnt[0] != '0;
  assign ne1       = cnt[1] != '0;
  assign dsel      = (dturn ? ne1 : ne0) ? dturn : !dturn;
  assign deq_valid = ne0 || ne1;
  assign deq_tid   = dsel;
  assign deq_data  = mem[phys(dual_mode, dsel, head[dsel])];
  assign deq       = deq_valid && deq_ready;

  always_ff @(posedge clk) begin
    if (enq)
      mem[phys(dual_mode, etid, tail[etid])] <= etid ? t1_data : t0_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dual_mode <= 1'b0;
      eturn     <= 1'b0;
      dturn     <= 1'b0;
      head      <= '0;
      tail      <= '0;
      cnt       <= '0;
    end else begin
      if (pend && !deq_valid) begin
        dual_mode <= dual_req;
        head      <= '0;
        tail      <= '0;
      end
      if (enq) begin
        tail[etid] <= nxt(dual_mode, tail[etid]);
        eturn      <= !etid;
      end
      if (deq) begin
        head[dsel] <= nxt(dual_mode, head[dsel]);
        dturn      <= !dsel;
      end
      for (int t = 0; t < 2; t++)
        cnt[t] <= cnt[t] + CW'(enq && (etid == 1'(t))) - CW'(deq && (dsel == 1'(t)));
    end
  end
endmodule

// File: rtl/smt_iq_chk.sv
module smt_iq_chk #(
  parameter int N = 8,
  parameter int W = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         dual_req,
  input logic                         dual_mode,
  input logic                         t0_valid,
  input logic                         t0_ready,
  input logic                         t1_valid,
  input logic                         t1_ready,
  input logic                         deq_valid,
  input logic                         deq_ready,
  input logic                         deq_tid,
  input logic [1:0][$clog2(N):0]      cnt
);
  localparam int HALF = N / 2;

  // R5
  one_enq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(t0_valid && t0_ready && t1_valid && t1_ready));

  // R4
  single_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_mode |-> !t1_ready);

  // R8
  pend_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_req != dual_mode) |-> (!t0_ready && !t1_ready));

  // R8
  switch_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dual_mode) |-> $past(!deq_valid));

  // R3
  part_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dual_mode |-> (cnt[0] <= HALF && cnt[1] <= HALF));

  // R6
  deq_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && deq_ready && cnt[0] > 1 && cnt[1] > 1) |=> (deq_tid != $past(deq_tid)));
endmodule

bind smt_iq smt_iq_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dual_req(dual_req), .dual_mode(dual_mode),
  .t0_valid(t0_valid), .t0_ready(t0_ready), .t1_valid(t1_valid), .t1_ready(t1_ready),
  .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_tid(deq_tid), .cnt(cnt)
);

// File: tb/smt_iq_bench.sv
module smt_iq_bench;
  localparam int N = 8;
  localparam int W = 16;
  localparam int HALF = N / 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, dual_req, t0_valid, t0_ready, t1_valid, t1_ready;
  logic deq_ready, deq_valid, deq_tid, dual_mode;
  logic [W-1:0] t0_data, t1_data, deq_data;

  smt_iq #(.N(N), .W(W)) u_smt_iq (
    .clk(clk), .rst_n(rst_n), .dual_req(dual_req),
    .t0_valid(t0_valid), .t0_data(t0_data), .t0_ready(t0_ready),
    .t1_valid(t1_valid), .t1_data(t1_data), .t1_ready(t1_ready),
    .deq_ready(deq_ready), .deq_valid(deq_valid), .deq_data(deq_data),
    .deq_tid(deq_tid), .dual_mode(dual_mode)
  );

  int checks = 0;
  int errors = 0;
  logic [W-1:0] q0[$];
  logic [W-1:0] q1[$];
  bit mode_m = 0, eturn_m = 0, dturn_m = 0;
  logic [W-1:0] seq = 16'h0100;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v0, input bit v1, input bit dr);
    logic [W-1:0] d0, d1;
    bit pend, sp0, sp1, a0, a1, r0, r1, ne0, ne1, sel;
    int cap;
    d0 = seq;
    d1 = seq + 16'h1000;
    seq = seq + 1;
    t0_valid = v0; t0_data = d0;
    t1_valid = v1; t1_data = d1;
    deq_ready = dr;
    #1;
    pend = (dual_req != mode_m);
    cap = mode_m ? HALF : N;
    sp0 = !pend && (q0.size() < cap);
    sp1 = !pend && mode_m && (q1.size() < cap);
    a0 = v0 && sp0;
    a1 = v1 && sp1;
    r0 = sp0 && (!eturn_m || !a1);
    r1 = sp1 && (eturn_m || !a0);
    chk(t0_ready == r0, "R3 R4 R5 R7 R8 t0_ready", int'(t0_ready), int'(r0));
    chk(t1_ready == r1, "R3 R4 R5 R7 R8 t1_ready", int'(t1_ready), int'(r1));
    chk(dual_mode == mode_m, "R8 dual_mode", int'(dual_mode), int'(mode_m));
    ne0 = q0.size() != 0;
    ne1 = q1.size() != 0;
    sel = dturn_m ? (ne1 ? 1'b1 : 1'b0) : (ne0 ? 1'b0 : 1'b1);
    chk(deq_valid == (ne0 || ne1), "R6 deq_valid", int'(deq_valid), int'(ne0 || ne1));
    if (ne0 || ne1) begin
      chk(deq_tid == sel, "R6 deq_tid", int'(deq_tid), int'(sel));
      chk(deq_data == (sel ? q1[0] : q0[0]), "R2 R9 deq_data",
          int'(deq_data), int'(sel ? q1[0] : q0[0]));
    end
    @(posedge clk);
    if (pend && !ne0 && !ne1) mode_m = dual_req;
    if ((ne0 || ne1) && dr) begin
      if (sel) void'(q1.pop_front()); else void'(q0.pop_front());
      dturn_m = !sel;
    end
    if (v0 && r0) begin q0.push_back(d0); eturn_m = 1'b1; end
    else if (v1 && r1) begin q1.push_back(d1); eturn_m = 1'b0; end
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(deq_valid == 1'b0, "R1 deq_valid", int'(deq_valid), 0);
    chk(dual_mode == 1'b0, "R1 dual_mode", int'(dual_mode), 0);
    chk(t1_ready == 1'b0, "R1 t1_ready", int'(t1_ready), 0);
    chk(t0_ready == 1'b1, "R1 t0_ready", int'(t0_ready), 1);
  endtask

  task automatic t_single_fill;
    repeat (10) step(1, 1, 0);
    chk(q0.size() == N, "R4 full depth", q0.size(), N);
    repeat (9) step(0, 0, 1);
  endtask

  task automatic t_switch_wait;
    repeat (2) step(1, 0, 0);
    dual_req = 1'b1;
    repeat (5) step(1, 1, 1);
    chk(dual_mode == 1'b1, "R8 switched", int'(dual_mode), 1);
    repeat (6) step(0, 0, 1);
  endtask

  task automatic t_partition;
    repeat (6) step(1, 0, 0);
    chk(q0.size() == HALF, "R3 t0 half", q0.size(), HALF);
    repeat (5) step(1, 1, 0);
    chk(q1.size() == HALF, "R3 t1 half", q1.size(), HALF);
    step(1, 1, 1);
    step(1, 1, 0);
    repeat (12) step(0, 0, 1);
  endtask

  task automatic t_alternate;
    repeat (6) step(1, 1, 0);
    repeat (8) step(0, 0, 1);
  endtask

  task automatic t_flow;
    repeat (4) step(0, 1, 0);
    repeat (12) step(1, 0, 1);
    repeat (12) step(1, 1, 1);
    repeat (10) step(0, 0, 1);
  endtask

  task automatic t_back_single;
    repeat (3) step(1, 1, 0);
    dual_req = 1'b0;
    repeat (6) step(1, 1, 1);
    chk(dual_mode == 1'b0, "R8 back to single", int'(dual_mode), 0);
    repeat (10) step(1, 1, 1);
    repeat (10) step(0, 0, 1);
  endtask

  initial begin
    rst_n = 1'b0; dual_req = 1'b0;
    t0_valid = 1'b0; t1_valid = 1'b0; t0_data = '0; t1_data = '0; deq_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_single_fill();
    t_switch_wait();
    t_partition();
    t_alternate();
    t_flow();
    t_back_single();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule